// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

A single timer channel that counts down by one on every strobe from a shared prescaler tick while it is enabled. Software programs it through three write strobes that share one data bus: a direct counter write, a reload value write and a control write. The counter, the reload value and the control/status word are always visible on output ports for a register read path outside the block.

The channel expires when a tick arrives while the counter already holds zero, so a start value of N gives N+1 ticks before expiry. On expiry it can raise a sticky pending flag together with a one-cycle interrupt pulse. It can then either reload from the reload register and keep running, or stop with the counter wrapped to all ones. A load command in the control write copies the reload value into the counter and starts it in the same write. Two further control bits (chain, debug halt) are kept for software but do nothing.

Top module: `tmr_chan`

## Requirements
- R1: After reset the counter, the reload value and the control word read 0, and irq_o is low.
- R2: With enable (control bit 0) set, a tick while the counter is nonzero lowers it by one at the next edge. With enable clear, or with no tick, the counter holds its value.
- R3: A tick while enabled and the counter is 0 is an expiry, so a counter started at N expires on the (N+1)th tick.
- R4: On expiry with interrupt enable (bit 3) set, the pending bit (bit 4) is set and irq_o is high for exactly the one cycle after the expiring tick. With bit 3 clear, an expiry gives no pulse and leaves pending unchanged.
- R5: On expiry with restart (bit 1) set, the counter takes the reload value and enable stays set.
- R6: On expiry with restart clear, the counter becomes all ones and enable clears.
- R7: A control write with a 1 in bit 4 clears pending. A 0 in bit 4 leaves pending unchanged. The other stored bits take the written values.
- R8: If an expiry with interrupt enable set falls in the same cycle as a control write that clears pending, pending ends up set.
- R9: A control write with load (bit 2) set copies the reload value into the counter in that write, and no tick is counted in that cycle. Bit 2 always reads 0.
- R10: A counter write sets the counter to the written value. A tick in the same cycle is dropped.
- R11: Chain (bit 5) and debug halt (bit 6) read back as written and do not change counting.
- R12: A reload write stores the written value, and it reads back on rld_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick strobe |
| cnt_we_i | input | 1 | Counter write strobe |
| rld_we_i | input | 1 | Reload register write strobe |
| ctl_we_i | input | 1 | Control register write strobe |
| wdata_i | input | 32 | Write data shared by the three strobes |
| cnt_o | output | 32 | Current counter value |
| rld_o | output | 32 | Reload register value |
| ctl_o | output | 7 | Control/status word, bit 2 always 0 |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach is an expiry that lands in the same cycle as a control write clearing pending. A tick and a write strobe must coincide exactly when the counter is at zero. The directed part of the bench sets this up by loading a small value, stepping the counter to zero with single ticks, and then issuing the tick together with a pending-clear control write. Random traffic with small start values and frequent ticks hits expiry, restart and write collisions many more times. A bench model checks every cycle of that traffic.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CTL_W     = 7;
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_RST   = 1;
  localparam int unsigned BIT_LOAD  = 2;
  localparam int unsigned BIT_IE    = 3;
  localparam int unsigned BIT_PEND  = 4;
  localparam int unsigned BIT_CHAIN = 5;
  localparam int unsigned BIT_DBG   = 6;

  typedef struct packed {
    logic dbg;
    logic chain;
    logic pend;
    logic ie;
    logic load;
    logic restart;
    logic en;
  } ctl_t;
endpackage

// File: rtl/tmr_rld.sv
module tmr_rld #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rld_o <= '0;
    else if (we_i) rld_o <= wdata_i;
  end
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             cnt_we_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic run, zero;

  // writes take the cycle; a tick is dropped then
  assign run      = en_i && tick_i && !cnt_we_i && !load_i;
  assign zero     = (cnt_o == '0);
  assign expire_o = run && zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (cnt_we_i) cnt_o <= wdata_i;
    else if (load_i)   cnt_o <= rld_i;
    else if (run) begin
      if (!zero)          cnt_o <= cnt_o - 1'b1;
      else if (restart_i) cnt_o <= rld_i;
      else                cnt_o <= '1;
    end
  end
endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             expire_i,
  output ctl_t             ctl_o,
  output logic             irq_o
);
  logic set_pend;
  assign set_pend = expire_i && ctl_o.ie;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= set_pend;
      if (we_i) begin
        ctl_o.en      <= wdata_i[BIT_EN];
        ctl_o.restart <= wdata_i[BIT_RST];
        ctl_o.ie      <= wdata_i[BIT_IE];
        ctl_o.chain   <= wdata_i[BIT_CHAIN];
        ctl_o.dbg     <= wdata_i[BIT_DBG];
        // expiry set outranks a write-one clear
        ctl_o.pend    <= set_pend || (ctl_o.pend && !wdata_i[BIT_PEND]);
      end else begin
        if (set_pend) ctl_o.pend <= 1'b1;
        if (expire_i && !ctl_o.restart) ctl_o.en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic             rld_we_i,
  input  logic             ctl_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             irq_o
);
  ctl_t ctl_q;
  logic load_cmd, expire;

  assign load_cmd = ctl_we_i && wdata_i[BIT_LOAD];
  assign ctl_o    = ctl_q;

  tmr_rld #(.CNT_W(CNT_W)) u_rld (
    .clk_i, .rst_ni, .we_i(rld_we_i), .wdata_i, .rld_o
  );

  tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .en_i(ctl_q.en), .restart_i(ctl_q.restart),
    .cnt_we_i, .load_i(load_cmd), .wdata_i, .rld_i(rld_o),
    .cnt_o, .expire_o(expire)
  );

  tmr_ctl u_ctl (
    .clk_i, .rst_ni, .we_i(ctl_we_i), .wdata_i(wdata_i[CTL_W-1:0]),
    .expire_i(expire), .ctl_o(ctl_q), .irq_o
  );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned CTL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             cnt_we_i,
  input logic             rld_we_i,
  input logic             ctl_we_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] rld_o,
  input logic [CTL_W-1:0] ctl_o,
  input logic             irq_o
);
  logic quiet, at_zero_tick;
  assign quiet        = !cnt_we_i && !ctl_we_i;
  assign at_zero_tick = ctl_o[0] && tick_i && cnt_o == '0 && quiet;

  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_o[0] && quiet) |=> $stable(cnt_o)); // R2
  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[0] && tick_i && cnt_o != '0 && quiet) |=> cnt_o == $past(cnt_o) - 1'b1); // R2
  AST_IRQ_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctl_o[4]); // R4
  AST_RESTART_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_zero_tick && ctl_o[1]) |=> (cnt_o == $past(rld_o) && ctl_o[0])); // R5
  AST_STOP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_zero_tick && !ctl_o[1]) |=> (cnt_o == '1 && !ctl_o[0])); // R6
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[4] && !(ctl_we_i && wdata_i[4])) |=> ctl_o[4]); // R7
  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && wdata_i[2] && !cnt_we_i) |=> cnt_o == $past(rld_o)); // R9
  AST_CNT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(wdata_i)); // R10
  AST_RLD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rld_we_i |=> rld_o == $past(wdata_i)); // R12
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W), .CTL_W(tmr_pkg::CTL_W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .cnt_we_i, .rld_we_i, .ctl_we_i, .wdata_i,
  .cnt_o, .rld_o, .ctl_o, .irq_o
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, cwe = 0, rwe = 0, twe = 0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] cnt_o, rld_o;
  logic [6:0] ctl_o;
  logic irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [W-1:0] m_cnt = '0, m_rld = '0;
  logic [6:0] m_ctl = '0;
  logic m_irq = 0;

  tmr_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_we_i(cwe), .rld_we_i(rwe),
    .ctl_we_i(twe), .wdata_i(wd), .cnt_o, .rld_o, .ctl_o, .irq_o
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ctl_next(logic [6:0] c, bit we, logic [6:0] d, bit ex);
    logic set;
    logic [6:0] n;
    set = ex && c[3];
    n = c;
    if (we) begin
      n = {d[6:5], set | (c[4] & ~d[4]), d[3], 1'b0, d[1:0]};
    end else begin
      if (set) n[4] = 1'b1;
      if (ex && !c[1]) n[0] = 1'b0;
    end
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_rld <= '0; m_ctl <= '0; m_irq <= 0;
    end else begin
      automatic bit load = twe && wd[2];
      automatic bit run  = m_ctl[0] && tick && !cwe && !load;
      automatic bit ex   = run && m_cnt == '0;
      m_irq <= ex && m_ctl[3];
      m_ctl <= ctl_next(m_ctl, twe, wd[6:0], ex);
      if (rwe) m_rld <= wd;
      if (cwe) m_cnt <= wd;
      else if (load) m_cnt <= m_rld;
      else if (run) m_cnt <= (m_cnt != '0) ? m_cnt - 1 : (m_ctl[1] ? m_rld : '1);
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check("MODEL cnt", cnt_o, m_cnt);
    check("MODEL rld", rld_o, m_rld);
    check("MODEL ctl", W'(ctl_o), W'(m_ctl));
    check("MODEL irq", W'(irq_o), W'(m_irq));
  end

  task automatic cyc(bit t, bit c, bit r, bit k, logic [W-1:0] d);
    tick = t; cwe = c; rwe = r; twe = k; wd = d;
    @(negedge clk);
    tick = 0; cwe = 0; rwe = 0; twe = 0;
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cnt", cnt_o, 0); check("R1 rld", rld_o, 0);
    check("R1 ctl", W'(ctl_o), 0); check("R1 irq", W'(irq_o), 0);

    cyc(0, 0, 1, 0, 3);          check("R12 reload", rld_o, 3);
    cyc(0, 0, 0, 1, 'b1101);     check("R9 load copy", cnt_o, 3);
    check("R9 load reads 0", W'(ctl_o), 'b1001);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
    check("R2 decrement", cnt_o, 0); check("R3 no early expiry", W'(irq_o), 0);
    cyc(1, 0, 0, 0, 0);
    check("R3 expiry on 4th tick", W'(irq_o), 1);
    check("R4 pending", W'(ctl_o[4]), 1);
    check("R6 wrap", cnt_o, '1); check("R6 enable off", W'(ctl_o[0]), 0);
    cyc(1, 0, 0, 0, 0);
    check("R4 single pulse", W'(irq_o), 0);
    check("R2 hold disabled", cnt_o, '1);

    cyc(0, 0, 0, 1, 'b01000);    check("R7 keep pending", W'(ctl_o[4]), 1);
    cyc(0, 0, 0, 1, 'b11000);    check("R7 clear pending", W'(ctl_o[4]), 0);

    cyc(0, 0, 1, 0, 1);
    cyc(0, 0, 0, 1, 'b1111);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    check("R5 reload", cnt_o, 1); check("R5 enable kept", W'(ctl_o[0]), 1);
    check("R5 irq", W'(irq_o), 1);
    cyc(1, 0, 0, 0, 0);          check("R8 setup", cnt_o, 0);
    cyc(1, 0, 0, 1, 'b11011);
    check("R8 set wins", W'(ctl_o[4]), 1); check("R8 irq", W'(irq_o), 1);

    cyc(1, 1, 0, 0, 50);         check("R10 write beats tick", cnt_o, 50);
    cyc(0, 0, 0, 1, 'h71);       check("R11 readback", W'(ctl_o), 'h61);
    cyc(1, 0, 0, 0, 0);          check("R11 no effect", cnt_o, 49);
    cyc(0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    check("R4 no irq when ie clear", W'(irq_o), 0);
    check("R4 pending untouched", W'(ctl_o[4]), 0);
    check("R6 stop", W'(ctl_o[0]), 0);

    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom % 32;
      automatic logic [W-1:0] d = (r < 3) ? W'($urandom % 6) : W'($urandom % 128);
      if (r >= 3 && r < 5) d = d | 1;
      cyc(($urandom % 4) != 0, r == 0, r == 1, r >= 2 && r < 5, d);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule